// File: doc/BRIEF.md
# Serial EEPROM Write Command Parser

This block sits behind the bit-level engine of a two-wire serial slave and turns the received byte stream into write transactions for an EEPROM array. The bit engine reports start and stop conditions, each completed byte, and the moment it needs an acknowledge decision. The parser follows the command's byte sequence: one control byte, a high address byte, a low address byte, and then any number of data bytes. It decides for each byte whether to acknowledge, and it keeps an address pointer. For each accepted data byte it produces a one-cycle strobe carrying the target address and the data.

The control byte must carry device code 4'b1010 in bits [7:4] and the three configured select bits in bits [3:1]. Bit 0 must be 0, which marks a write. The address pointer is 15 bits wide, and bit 7 of the high address byte is discarded. After each data byte, the low six pointer bits advance and wrap inside a 64-byte page. A pending flag and a commit pulse at the stop condition tell the downstream commit controller when a page of data is ready. While that controller reports busy, the parser refuses every byte.

Top module: `eeprom_wr_parser`

## Requirements
- R1: Out of reset, `ack_drive`, `wr_strobe`, `wr_pend` and `commit` are low and `addr_ptr` is zero.
- R2: After a start, a control byte with bits [7:4]=4'b1010, bits [3:1]=`cfg_sel` and bit 0 = 0 is acknowledged, and the next byte is taken as the high address byte.
- R3: A control byte with a wrong device code, wrong select bits or bit 0 = 1 is not acknowledged. Every later byte is then refused and produces no strobe until the next start.
- R4: While `busy` is high, a received byte is not acknowledged and does not advance decoding: after `busy` falls, the same position in the command is expected again.
- R5: The high address byte loads pointer bits [14:8] from its bits [6:0], with bit 7 ignored. The low address byte loads bits [7:0]. Both bytes are acknowledged.
- R6: Every data byte is acknowledged. One cycle after the byte, `wr_strobe` pulses for one cycle with `wr_addr` equal to the pointer before the byte and `wr_data` equal to the byte.
- R7: After each data byte, pointer bits [5:0] increment and wrap from 63 to 0, while bits [14:6] are kept. After a single data byte the pointer therefore names the following location.
- R8: `wr_pend` rises after the first accepted data byte and stays high until a stop or a start. A stop with `wr_pend` high gives a one-cycle `commit` pulse on the next cycle. A stop with no data byte gives none.
- R9: A repeated start at any point clears `wr_pend` without a commit, and the next byte is decoded as a control byte.
- R10: `ack_drive` is high only while `ack_req` is high. A byte that arrives before any start is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 3 | Static select value matched against control bits [3:1] |
| busy | input | 1 | Commit controller is writing; refuse all bytes |
| bus_start | input | 1 | One-cycle pulse: start or repeated start seen |
| bus_stop | input | 1 | One-cycle pulse: stop seen |
| byte_vld | input | 1 | One-cycle pulse: `byte_data` holds a completed byte |
| byte_data | input | 8 | Received byte, MSB first order already resolved |
| ack_req | input | 1 | Bit engine is in the acknowledge slot of the last byte |
| ack_drive | output | 1 | Pull the data line low (acknowledge) |
| addr_ptr | output | 15 | Current address pointer |
| wr_strobe | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr | output | 15 | Target address of the strobed byte |
| wr_data | output | 8 | Data of the strobed byte |
| wr_pend | output | 1 | Data bytes collected and not yet committed or aborted |
| commit | output | 1 | One-cycle pulse: start the internal write |

## Verification
The bench sets bit 7 of the high address byte. A parser that kept that bit would report a pointer outside the 15-bit range. A write started two bytes before a page end must wrap to the page start: a carry into bit 6 would move the third byte into the next page. The bench feeds each of the three control-field faults (device code, select bits, read flag) separately, then sends further bytes. A parser that resynchronised on them would acknowledge or strobe garbage. The bench also holds busy across a control byte, then checks that a repeated start aborts a pending write without a commit, and that a stop after only address bytes commits nothing.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_ADR_HI,
        PH_ADR_LO,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] sel;
        logic       rd;
    } ctrl_byte_t;

    function automatic ctrl_byte_t split_ctrl(input logic [7:0] b);
        ctrl_byte_t c;
        c.code = b[7:4];
        c.sel  = b[3:1];
        c.rd   = b[0];
        return c;
    endfunction

endpackage

// File: rtl/eewp_ctrl_match.sv
module eewp_ctrl_match
    import eewp_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic [2:0] sel_cfg,
    output logic       is_mine
);
    ctrl_byte_t fields;

    always_comb begin
        fields  = split_ctrl(byte_in);
        is_mine = (fields.code == DEV_CODE) && (fields.sel == sel_cfg) && !fields.rd;
    end
endmodule

// File: rtl/eewp_addr_ptr.sv
module eewp_addr_ptr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              bump,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page_next;
    logic [15:0]       hi_word;

    always_comb begin
        page_next = ptr[PAGE_W-1:0] + PAGE_W'(1);
        hi_word   = {din, ptr[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld_hi) begin
            ptr <= ADDR_W'(hi_word);
        end else if (ld_lo) begin
            ptr <= {ptr[ADDR_W-1:8], din};
        end else if (bump) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], page_next};
        end
    end

    if (HI_W < 1 || PAGE_W > 8) begin : g_bad_cfg
        initial $display("eewp_addr_ptr: unsupported ADDR_W/PAGE_W");
    end
endmodule

// File: rtl/eewp_seq.sv
module eewp_seq
    import eewp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    input  logic vld_i,
    input  logic busy_i,
    input  logic ctrl_ok,
    output logic ack_hold,
    output logic ld_hi,
    output logic ld_lo,
    output logic take_data,
    output logic pend,
    output logic commit_o
);
    phase_t phase;
    logic   take;

    always_comb begin
        take      = vld_i && !busy_i && !start_i && !stop_i;
        ld_hi     = take && (phase == PH_ADR_HI);
        ld_lo     = take && (phase == PH_ADR_LO);
        take_data = take && (phase == PH_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ack_hold <= 1'b0;
            pend     <= 1'b0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (start_i) begin
                phase    <= PH_CTRL;
                ack_hold <= 1'b0;
                pend     <= 1'b0;
            end else if (stop_i) begin
                phase    <= PH_IDLE;
                ack_hold <= 1'b0;
                commit_o <= pend;
                pend     <= 1'b0;
            end else if (vld_i) begin
                if (busy_i) begin
                    ack_hold <= 1'b0;
                end else begin
                    unique case (phase)
                        PH_CTRL: begin
                            ack_hold <= ctrl_ok;
                            phase    <= ctrl_ok ? PH_ADR_HI : PH_SKIP;
                        end
                        PH_ADR_HI: begin
                            ack_hold <= 1'b1;
                            phase    <= PH_ADR_LO;
                        end
                        PH_ADR_LO: begin
                            ack_hold <= 1'b1;
                            phase    <= PH_DATA;
                        end
                        PH_DATA: begin
                            ack_hold <= 1'b1;
                            pend     <= 1'b1;
                        end
                        default: ack_hold <= 1'b0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_wr_parser.sv
module eeprom_wr_parser #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_sel,
    input  logic              busy,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              ack_req,
    output logic              ack_drive,
    output logic [ADDR_W-1:0] addr_ptr,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_pend,
    output logic              commit
);
    logic ctrl_ok;
    logic ack_hold;
    logic ld_hi, ld_lo, take_data;

    eewp_ctrl_match u_match (
        .byte_in (byte_data),
        .sel_cfg (cfg_sel),
        .is_mine (ctrl_ok)
    );

    eewp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (bus_start),
        .stop_i    (bus_stop),
        .vld_i     (byte_vld),
        .busy_i    (busy),
        .ctrl_ok   (ctrl_ok),
        .ack_hold  (ack_hold),
        .ld_hi     (ld_hi),
        .ld_lo     (ld_lo),
        .take_data (take_data),
        .pend      (wr_pend),
        .commit_o  (commit)
    );

    eewp_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .ld_hi (ld_hi),
        .ld_lo (ld_lo),
        .bump  (take_data),
        .din   (byte_data),
        .ptr   (addr_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_strobe <= take_data;
            if (take_data) begin
                wr_addr <= addr_ptr;
                wr_data <= byte_data;
            end
        end
    end

    assign ack_drive = ack_req && ack_hold;
endmodule

// File: rtl/eewp_checker.sv
module eewp_checker #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              byte_vld,
    input logic              ack_hold,
    input logic [ADDR_W-1:0] addr_ptr,
    input logic              wr_strobe,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_pend,
    input logic              commit
);
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
        busy && byte_vld && !bus_start && !bus_stop |=> !ack_hold && !wr_strobe); // R4

    AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> ack_hold && wr_pend); // R6

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (addr_ptr[PAGE_W-1:0] == PAGE_W'(wr_addr[PAGE_W-1:0] + 1'b1))
                   && (addr_ptr[ADDR_W-1:PAGE_W] == wr_addr[ADDR_W-1:PAGE_W])); // R7

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(bus_stop)); // R8

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !wr_pend && !ack_hold && !commit); // R9
endmodule

bind eeprom_wr_parser eewp_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .byte_vld  (byte_vld),
    .ack_hold  (ack_hold),
    .addr_ptr  (addr_ptr),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_pend   (wr_pend),
    .commit    (commit)
);

// File: tb/eeprom_wr_parser_tb.sv
module eeprom_wr_parser_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_sel = 3'b101;
    logic        busy = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        ack_req = 1'b0;
    logic        ack_drive;
    logic [14:0] addr_ptr;
    logic        wr_strobe;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_pend;
    logic        commit;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    logic        r_ack, r_stb;
    logic [14:0] r_wa;
    logic [7:0]  r_wd;

    localparam logic [7:0] CTRL_OK = 8'hAA;

    always #4 clk = ~clk;

    eeprom_wr_parser u_dut (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .busy(busy),
        .bus_start(bus_start), .bus_stop(bus_stop), .byte_vld(byte_vld),
        .byte_data(byte_data), .ack_req(ack_req), .ack_drive(ack_drive),
        .addr_ptr(addr_ptr), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_pend(wr_pend), .commit(commit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        ack_req  = 1'b1;
        #1;
        r_ack = ack_drive;
        r_stb = wr_strobe;
        r_wa  = wr_addr;
        r_wd  = wr_data;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic do_stop(input logic exp_commit, input string req);
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        #1;
        check({req, " commit pulse"}, commit, exp_commit);
        check({req, " pend cleared at stop"}, wr_pend, 1'b0);
        @(negedge clk);
        check({req, " commit one cycle"}, commit, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 ptr zero", addr_ptr, 0);
        check("R1 strobe low", wr_strobe, 0);
        check("R1 pend low", wr_pend, 0);
        check("R1 commit low", commit, 0);
        send_byte(CTRL_OK);
        check("R10 byte before start nacked", r_ack, 0);
        check("R10 no strobe before start", r_stb, 0);
    endtask

    task automatic t_single();
        do_start();
        send_byte(CTRL_OK);
        check("R2 control acked", r_ack, 1);
        #1;
        check("R10 ack only during ack_req", ack_drive, 0);
        send_byte(8'h92);
        check("R5 high addr acked", r_ack, 1);
        send_byte(8'h34);
        check("R5 low addr acked", r_ack, 1);
        check("R5 pointer loaded, bit7 dropped", addr_ptr, 15'h1234);
        send_byte(8'h5A);
        check("R6 data acked", r_ack, 1);
        check("R6 strobe", r_stb, 1);
        check("R6 strobe addr", r_wa, 15'h1234);
        check("R6 strobe data", r_wd, 8'h5A);
        check("R6 strobe single cycle", wr_strobe, 0);
        check("R7 pointer next", addr_ptr, 15'h1235);
        check("R8 pend set", wr_pend, 1);
        do_stop(1'b1, "R8");
    endtask

    task automatic t_page_wrap();
        do_start();
        send_byte(CTRL_OK);
        send_byte(8'h00);
        send_byte(8'h7E);
        send_byte(8'h11);
        check("R7 wrap addr 1", r_wa, 15'h007E);
        send_byte(8'h22);
        check("R7 wrap addr 2", r_wa, 15'h007F);
        send_byte(8'h33);
        check("R7 wrap to page start", r_wa, 15'h0040);
        check("R6 wrap data", r_wd, 8'h33);
        check("R7 pointer after wrap", addr_ptr, 15'h0041);
        do_stop(1'b1, "R8");
    endtask

    task automatic t_mismatch();
        logic [7:0] bad [3];
        bad[0] = 8'hBA;
        bad[1] = 8'hA8;
        bad[2] = 8'hAB;
        for (int i = 0; i < 3; i++) begin
            do_start();
            send_byte(bad[i]);
            check("R3 bad control nacked", r_ack, 0);
            send_byte(8'h00);
            check("R3 later byte nacked", r_ack, 0);
            send_byte(8'h10);
            send_byte(CTRL_OK);
            check("R3 still ignored", r_ack, 0);
            check("R3 no strobe", r_stb, 0);
            check("R3 no pend", wr_pend, 0);
            do_stop(1'b0, "R3");
        end
    endtask

    task automatic t_busy();
        do_start();
        busy = 1'b1;
        send_byte(CTRL_OK);
        check("R4 busy control nacked", r_ack, 0);
        busy = 1'b0;
        send_byte(CTRL_OK);
        check("R4 control still expected", r_ack, 1);
        send_byte(8'h01);
        send_byte(8'h02);
        busy = 1'b1;
        send_byte(8'h77);
        check("R4 busy data nacked", r_ack, 0);
        check("R4 busy no strobe", r_stb, 0);
        check("R4 pointer held", addr_ptr, 15'h0102);
        busy = 1'b0;
        do_stop(1'b0, "R8 stop without data");
    endtask

    task automatic t_restart();
        do_start();
        send_byte(CTRL_OK);
        send_byte(8'h03);
        send_byte(8'h00);
        send_byte(8'h44);
        check("R9 pend before restart", wr_pend, 1);
        do_start();
        #1;
        check("R9 pend aborted", wr_pend, 0);
        check("R9 no commit on restart", commit, 0);
        send_byte(CTRL_OK);
        check("R9 control after restart", r_ack, 1);
        send_byte(8'h05);
        send_byte(8'h3F);
        send_byte(8'h99);
        check("R9 write after restart", r_wa, 15'h053F);
        check("R7 wrap single byte", addr_ptr, 15'h0500);
        do_start();
        send_byte(8'h05);
        check("R9 addr byte after start is control", r_ack, 0);
        do_stop(1'b0, "R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_single();
        t_page_wrap();
        t_mismatch();
        t_busy();
        t_restart();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule